// File: doc/BRIEF.md
# Walsh Spectrum Bit-Stream Perturbation Engine

The engine takes a serial stream of N test bits for one circuit input and produces a new stream of N bits. The new stream keeps the dominant Walsh components of the original and scrambles the rest. Each received bit becomes a signed sample: a 1 becomes +1 and a 0 becomes -1. A fast in-place butterfly network then forms the Walsh-Hadamard spectrum, which is the correlation of the signed samples with every row of the naturally ordered Sylvester Hadamard matrix.

A coefficient counts as dominant when its share of the total spectral power reaches a programmable multiple of the share that a random stream would give, which is 1/N. Dominant coefficients are kept as they are. Every other coefficient is overwritten with a bounded value from a 16-bit LFSR. The same butterflies run a second time to rebuild the stream. The sign of each rebuilt sum decides the output bit.

A controller supplies a start pulse, a power-threshold multiplier and a seed for each stream. It pushes the bits in over a valid/ready port and drains the result from a second valid/ready port. A one-cycle done pulse marks the end of each stream.

Top module: `wht_perturb_engine`

## Requirements
- R1: With a threshold multiplier of 0, every coefficient is kept, so the output stream equals the input stream bit for bit.
- R2: Coefficient k (row k of the Sylvester Hadamard matrix, element (k,j) = -1 when popcount(k AND j) is odd, else +1) is kept unchanged when coef_k² × N ≥ thr × Σ coef², where thr is the multiplier sampled at start.
- R3: Any other coefficient is replaced by the low log2(N) bits of a 16-bit right-shifting Galois LFSR (feedback mask 0xB400 applied when the bit shifted out is 1), read as two's complement. Coefficients are visited in index order 0..N-1, the current state is used first, and the LFSR then steps once per index, whether the coefficient is kept or not.
- R4: A seed of 0 sampled at start is replaced by 0x0001.
- R5: Output bit j is 1 when rebuilt sum j is positive, 0 when it is negative, and input bit j when it is zero. Bits leave in index order 0..N-1, and the first bit accepted on input is index 0.
- R6: inReady is high only while the engine is collecting input. It never overlaps outValid, and exactly N input handshakes are taken per stream.
- R7: While outValid is high and outReady is low, outValid stays high and outBit holds its value on the next cycle.
- R8: done is high for exactly one cycle, the cycle after the handshake of output bit N-1, and the engine is then idle with inReady and outValid low.
- R9: A start pulse outside the idle state has no effect. The threshold and seed are sampled only on an accepted start, so later changes on those inputs do not alter the stream.
- R10: After reset, inReady, outValid and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new stream (idle only) |
| thrScale | input | TH_W | Power-threshold multiplier, sampled at start |
| seed | input | 16 | LFSR seed, sampled at start |
| inValid | input | 1 | Input bit offered |
| inReady | output | 1 | Engine accepts an input bit |
| inBit | input | 1 | Input stream bit |
| outValid | output | 1 | Output bit offered |
| outReady | input | 1 | Consumer accepts the output bit |
| outBit | output | 1 | Regenerated stream bit |
| done | output | 1 | One-cycle pulse after the last output handshake |

## Verification
After the N-th input handshake, the first output bit appears after a fixed delay of log2(N) forward cycles, N perturbation cycles and log2(N) inverse cycles. The bench does not count that delay. It polls outValid at falling edges and takes one bit for each cycle in which outValid and its own randomly driven outReady are both high. done is due on the falling edge right after the edge of the final handshake and must be low one cycle later, and the bench samples at exactly those two points. Each captured stream is compared as a whole with a bench model. The model builds the Hadamard matrix directly rather than through butterflies, and it computes the full power sum.

// File: rtl/wht_pkg.sv
package wht_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_FWD,
    ST_PERT,
    ST_INV,
    ST_OUT
  } wht_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchCfg;
    logic capture;
    logic bfly;
    logic perturb;
  } wht_strobe_t;

  localparam logic [15:0] LFSR_MASK = 16'hB400;

endpackage

// File: rtl/wht_ctrl.sv
module wht_ctrl
  import wht_pkg::*;
#(
  parameter int N = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic                    inValid,
  input  logic                    outReady,
  output logic                    inReady,
  output logic                    outValid,
  output logic                    done,
  output logic [$clog2(N)-1:0]    cnt,
  output wht_strobe_t             strb
);

  localparam int LOG2N = $clog2(N);
  localparam logic [LOG2N-1:0] LAST_IDX   = LOG2N'(N - 1);
  localparam logic [LOG2N-1:0] LAST_STAGE = LOG2N'(LOG2N - 1);

  wht_state_e state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_LOAD;
          cnt   <= '0;
        end
        ST_LOAD: if (inValid) begin
          if (cnt == LAST_IDX) begin
            state <= ST_FWD;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_FWD: begin
          if (cnt == LAST_STAGE) begin
            state <= ST_PERT;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_PERT: begin
          if (cnt == LAST_IDX) begin
            state <= ST_INV;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_INV: begin
          if (cnt == LAST_STAGE) begin
            state <= ST_OUT;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_OUT: if (outReady) begin
          if (cnt == LAST_IDX) begin
            state <= ST_IDLE;
            cnt   <= '0;
            done  <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign inReady  = (state == ST_LOAD);
  assign outValid = (state == ST_OUT);

  always_comb begin
    strb.latchCfg = (state == ST_IDLE) && start;
    strb.capture  = (state == ST_LOAD) && inValid;
    strb.bfly     = (state == ST_FWD) || (state == ST_INV);
    strb.perturb  = (state == ST_PERT);
  end

endmodule

// File: rtl/wht_datapath.sv
module wht_datapath
  import wht_pkg::*;
#(
  parameter int N    = 16,
  parameter int TH_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  wht_strobe_t           strb,
  input  logic [$clog2(N)-1:0]  cnt,
  input  logic [TH_W-1:0]       thrScale,
  input  logic [15:0]           seed,
  input  logic                  inBit,
  output logic                  outBit
);

  localparam int LOG2N = $clog2(N);
  // rebuilt sums reach N*N, so the array is wider than the forward range
  localparam int ACC_W = 2 * LOG2N + 2;
  localparam int SQ_W  = 2 * ACC_W;
  localparam int CMP_W = SQ_W + TH_W;
  localparam logic signed [ACC_W-1:0] PLUS_ONE  = ACC_W'(1);
  localparam logic signed [ACC_W-1:0] MINUS_ONE = -ACC_W'(1);

  logic signed [ACC_W-1:0] val  [N];
  logic signed [ACC_W-1:0] nxt  [N];
  logic        [N-1:0]     orig;
  logic        [15:0]      lfsr;
  logic        [TH_W-1:0]  thrQ;

  // one butterfly stage, stage number in cnt
  always_comb begin
    for (int j = 0; j < N; j++) begin
      logic [LOG2N-1:0] jj;
      logic [LOG2N-1:0] pp;
      jj = LOG2N'(j);
      pp = jj ^ (LOG2N'(1) << cnt);
      if (!jj[cnt]) nxt[j] = val[j] + val[pp];
      else          nxt[j] = val[pp] - val[j];
    end
  end

  // keep / replace decision for coefficient cnt
  logic signed [ACC_W-1:0] cur;
  logic        [ACC_W-1:0] mag;
  logic        [SQ_W-1:0]  sq;
  logic        [CMP_W-1:0] limit;
  logic                    keep;
  logic signed [ACC_W-1:0] noiseVal;
  logic        [15:0]      lfsrNext;

  always_comb begin
    cur      = val[cnt];
    mag      = cur[ACC_W-1] ? ACC_W'(-cur) : ACC_W'(cur);
    sq       = SQ_W'(mag) * SQ_W'(mag);
    // total power is N*N for any +/-1 stream, so coef^2*N >= thr*N*N
    // reduces to coef^2 >= thr*N
    limit    = CMP_W'(thrQ) << LOG2N;
    keep     = CMP_W'(sq) >= limit;
    noiseVal = {{(ACC_W - LOG2N){lfsr[LOG2N-1]}}, lfsr[LOG2N-1:0]};
    lfsrNext = lfsr[0] ? ((lfsr >> 1) ^ LFSR_MASK) : (lfsr >> 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsr <= 16'h0001;
      thrQ <= '0;
      orig <= '0;
      for (int j = 0; j < N; j++) val[j] <= '0;
    end else begin
      if (strb.latchCfg) begin
        lfsr <= (seed == 16'h0000) ? 16'h0001 : seed;
        thrQ <= thrScale;
      end
      if (strb.capture) begin
        val[cnt]  <= inBit ? PLUS_ONE : MINUS_ONE;
        orig[cnt] <= inBit;
      end
      if (strb.bfly) begin
        for (int j = 0; j < N; j++) val[j] <= nxt[j];
      end
      if (strb.perturb) begin
        if (!keep) val[cnt] <= noiseVal;
        lfsr <= lfsrNext;
      end
    end
  end

  // sign decision, ties fall back to the original bit
  always_comb begin
    if (cur == '0)            outBit = orig[cnt];
    else if (cur[ACC_W-1])    outBit = 1'b0;
    else                      outBit = 1'b1;
  end

endmodule

// File: rtl/wht_perturb_engine.sv
module wht_perturb_engine
  import wht_pkg::*;
#(
  parameter int N    = 16,
  parameter int TH_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [TH_W-1:0] thrScale,
  input  logic [15:0]     seed,
  input  logic            inValid,
  output logic            inReady,
  input  logic            inBit,
  output logic            outValid,
  input  logic            outReady,
  output logic            outBit,
  output logic            done
);

  localparam int LOG2N = $clog2(N);

  wht_strobe_t      strb;
  logic [LOG2N-1:0] cnt;

  wht_ctrl #(.N(N)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .done     (done),
    .cnt      (cnt),
    .strb     (strb)
  );

  wht_datapath #(.N(N), .TH_W(TH_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cnt      (cnt),
    .thrScale (thrScale),
    .seed     (seed),
    .inBit    (inBit),
    .outBit   (outBit)
  );

endmodule

// File: rtl/wht_perturb_chk.sv
module wht_perturb_chk (
  input logic clk,
  input logic rstN,
  input logic inReady,
  input logic outValid,
  input logic outReady,
  input logic outBit,
  input logic done
);

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outBit)));

  // R6
  port_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({inReady, outValid, done}));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  done_after_hs_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(outValid && outReady));

  // R8
  out_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outValid) |-> done);

endmodule

bind wht_perturb_engine wht_perturb_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inReady  (inReady),
  .outValid (outValid),
  .outReady (outReady),
  .outBit   (outBit),
  .done     (done)
);

// File: tb/tb_wht_perturb_engine.sv
module tb_wht_perturb_engine;

  localparam int N    = 16;
  localparam int TH_W = 8;
  localparam int LOG2N = $clog2(N);

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            start = 1'b0;
  logic [TH_W-1:0] thrScale = '0;
  logic [15:0]     seed = '0;
  logic            inValid = 1'b0;
  logic            inReady;
  logic            inBit = 1'b0;
  logic            outValid;
  logic            outReady = 1'b0;
  logic            outBit;
  logic            done;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  wht_perturb_engine #(.N(N), .TH_W(TH_W)) dut (
    .clk(clk), .rstN(rstN), .start(start), .thrScale(thrScale), .seed(seed),
    .inValid(inValid), .inReady(inReady), .inBit(inBit),
    .outValid(outValid), .outReady(outReady), .outBit(outBit), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] lfsrStep(input logic [15:0] s);
    return s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
  endfunction

  // reference: direct matrix products, full power sum
  function automatic logic [N-1:0] model(input logic [N-1:0] b, input int thr,
                                         input logic [15:0] sd);
    int c [N];
    int p [N];
    int tot;
    logic [15:0] l;
    logic [N-1:0] r;
    tot = 0;
    for (int k = 0; k < N; k++) begin
      c[k] = 0;
      for (int j = 0; j < N; j++)
        c[k] += (($countones(k & j) % 2) ? -1 : 1) * (b[j] ? 1 : -1);
      tot += c[k] * c[k];
    end
    l = (sd == 16'h0) ? 16'h1 : sd;
    for (int k = 0; k < N; k++) begin
      if (c[k] * c[k] * N >= thr * tot) p[k] = c[k];
      else begin
        int v;
        v = int'(l) & (N - 1);
        if (v >= N / 2) v -= N;
        p[k] = v;
      end
      l = lfsrStep(l);
    end
    for (int j = 0; j < N; j++) begin
      int s;
      s = 0;
      for (int k = 0; k < N; k++)
        s += (($countones(k & j) % 2) ? -1 : 1) * p[k];
      r[j] = (s > 0) ? 1'b1 : (s < 0) ? 1'b0 : b[j];
    end
    return r;
  endfunction

  task automatic runCase(input logic [N-1:0] bits, input int thr,
                         input logic [15:0] sd, input string req, input bit poke);
    logic [N-1:0] expect_v;
    logic [N-1:0] got;
    int k;
    int n;
    bit prevStall;
    logic prevBit;
    expect_v = model(bits, thr, sd);
    @(negedge clk);
    thrScale = TH_W'(thr);
    seed = sd;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    thrScale = TH_W'($urandom);   // R9: changes after start must not matter
    seed = 16'($urandom);
    k = 0;
    while (k < N) begin
      bit acc;
      inValid = ($urandom % 4) != 0;
      inBit = bits[k];
      start = poke && (k == N / 2);  // R9: ignored while busy
      acc = inValid && inReady;
      @(negedge clk);
      if (acc) k++;
    end
    inValid = 1'b0;
    start = 1'b0;
    check(!inReady, "R6", "inReady after N bits", inReady, 0);
    got = '0;
    n = 0;
    prevStall = 0;
    prevBit = 1'b0;
    while (n < N) begin
      outReady = ($urandom % 3) != 0;
      if (prevStall)
        check(outValid && (outBit == prevBit), "R7", "stall hold", outBit, prevBit);
      if (outValid && outReady) begin
        got[n] = outBit;
        n++;
      end
      prevStall = outValid && !outReady;
      prevBit = outBit;
      @(negedge clk);
    end
    outReady = 1'b0;
    check(done == 1'b1, "R8", "done after last handshake", done, 1);
    @(negedge clk);
    check(!done && !outValid && !inReady, "R8", "single pulse then idle",
          {done, outValid, inReady}, 0);
    check(got == expect_v, req, "output stream", got, expect_v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R10
    check(!inReady && !outValid && !done, "R10", "reset outputs",
          {inReady, outValid, done}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!inReady, "R6", "idle inReady low", inReady, 0);
    inValid = 1'b1;
    @(negedge clk);
    check(!inReady && !outValid, "R6", "no accept without start",
          {inReady, outValid}, 0);
    inValid = 1'b0;

    // R1: threshold 0 keeps every coefficient
    runCase(16'hA5C3, 0, 16'h1D2F, "R1", 0);
    runCase(16'h0001, 0, 16'h0077, "R1", 0);
    // R2 R3: mid thresholds mix kept and replaced coefficients
    runCase(16'hFF00, 1, 16'hACE1, "R2", 0);
    runCase(16'h5555, 2, 16'h0BAD, "R2", 0);
    // R3: every coefficient replaced
    runCase(16'h3C96, 255, 16'hBEEF, "R3", 0);
    // R4: zero seed
    runCase(16'h9F12, 255, 16'h0000, "R4", 0);
    // R5: all-equal streams give ties in rebuilt sums
    runCase(16'hFFFF, 3, 16'h0101, "R5", 0);
    runCase(16'h0000, 200, 16'h4242, "R5", 0);
    // R9: start pulse during input collection
    runCase(16'h7E81, 1, 16'h3141, "R9", 1);
    for (int i = 0; i < 10; i++) begin
      logic [N-1:0] b;
      int t;
      b = N'($urandom);
      t = $urandom % 5;
      runCase(b, t, 16'($urandom), "R2", (i % 3) == 0);
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule